// File: doc/BRIEF.md
# Accumulating ALU with Feedback Register

This block places an 8-bit result register behind a combinational arithmetic and logic unit with eight selectable operations. One operand comes from a 4-bit external data input. The other operand is always the low nibble of the register's current contents. Each operation therefore builds on the value the previous cycle left behind, and a sequence of operations accumulates.

A 3-bit function select chooses the operation. The choices are two adders that must agree (one built from chained full adders, one written with the language's addition operator), sign extension of the fed-back nibble, any-bit and all-bits tests over both operands together, a variable left shift, a 4x4 multiply, and a hold code that keeps the register unchanged. An active-low synchronous reset clears the register. Reset takes priority over every function code, hold included.

Top module: `accum_alu`

## Requirements
- R1: When rst_n is 0 at a rising edge of clk, result is 0 after that edge, whatever op_sel holds (hold included).
- R2: op_sel = 3'd0 loads the 8-bit zero-extended sum data_a + result[3:0], produced by a chain of full adders, with the carry-out in bit 4.
- R3: op_sel = 3'd1 loads the same zero-extended sum data_a + result[3:0], produced by the behavioural addition operator.
- R4: op_sel = 3'd2 loads result[3:0] sign-extended to 8 bits: bit 3 of the nibble is copied into bits 7..4.
- R5: op_sel = 3'd3 loads 8'h01 when any of the eight bits of {data_a, result[3:0]} is 1, and 8'h00 otherwise.
- R6: op_sel = 3'd4 loads 8'h01 only when all eight bits of {data_a, result[3:0]} are 1, and 8'h00 otherwise.
- R7: op_sel = 3'd5 loads result[3:0], zero-extended, shifted left by data_a positions and truncated to 8 bits. A shift of 8 or more gives 0.
- R8: op_sel = 3'd6 loads the 8-bit product data_a * result[3:0].
- R9: op_sel = 3'd7 leaves result unchanged at the edge, whatever data_a holds.
- R10: The second operand is always bits [3:0] of the value result held before the edge, so consecutive operations accumulate. Bits [7:4] never feed the ALU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_a | input | 4 | External operand A |
| op_sel | input | 3 | Operation select (codes 0..7) |
| result | output | 8 | Registered ALU result; its low nibble is operand B |

## Verification
Operand B cannot be driven from outside, so the difficult part is putting a chosen nibble into the register before each operation under test. The bench loads it by resetting the register and then adding the wanted value to zero with function 1. From that known B it applies each boundary pattern: B = 15 with A = 15 for the carry into bit 4 and for the maximum product, B = 8 for a negative sign extension, and shift amounts of 7 and 8 around truncation. Accumulation runs use the real feedback path, so that bits 7..4 are seen to be dropped from operand B.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    localparam int OPND_W_DEF = 4;
    localparam int RES_W_DEF  = 8;
    localparam int OP_W       = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_RC = 3'd0,
        OP_ADD_BH = 3'd1,
        OP_SEXT   = 3'd2,
        OP_ANY    = 3'd3,
        OP_ALL    = 3'd4,
        OP_SHL    = 3'd5,
        OP_MUL    = 3'd6,
        OP_HOLD   = 3'd7
    } alu_op_e;

endpackage

// File: rtl/ripple_adder.sv
module ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         c_in,
    output logic [W:0]   sum_out
);
    logic [W:0] carry;

    assign carry[0] = c_in;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p_bit;
        assign p_bit         = x_in[i] ^ y_in[i];
        assign sum_out[i]    = p_bit ^ carry[i];
        assign carry[i+1]    = (x_in[i] & y_in[i]) | (p_bit & carry[i]);
    end

    assign sum_out[W] = carry[W];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import accum_alu_pkg::*;
#(
    parameter int DW = OPND_W_DEF,
    parameter int RW = RES_W_DEF
) (
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [DW:0]    rc_sum,
    output logic [RW-1:0]  y
);
    localparam int CAT_W = 2 * DW;

    logic [CAT_W-1:0] both_opnd;
    logic [RW-1:0]    a_ext;
    logic [RW-1:0]    b_ext;

    assign both_opnd = {a, b};
    assign a_ext     = RW'(a);
    assign b_ext     = RW'(b);

    always_comb begin
        y = '0;
        unique case (op)
            OP_ADD_RC: y = RW'(rc_sum);
            OP_ADD_BH: y = a_ext + b_ext;
            OP_SEXT:   y = {{(RW-DW){b[DW-1]}}, b};
            OP_ANY:    y = RW'(|both_opnd);
            OP_ALL:    y = RW'(&both_opnd);
            OP_SHL:    y = b_ext << a;
            OP_MUL:    y = a_ext * b_ext;
            OP_HOLD:   y = '0;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_alu_pkg::*;
#(
    parameter int DW = OPND_W_DEF,
    parameter int RW = RES_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data_a,
    input  logic [2:0]    op_sel,
    output logic [RW-1:0] result
);
    typedef struct packed {
        logic [RW-1:0] acc;
    } acc_state_t;

    acc_state_t     state_d, state_q;
    alu_op_e        op_e;
    logic [DW-1:0]  opnd_b;
    logic [DW:0]    rc_sum;
    logic [RW-1:0]  alu_y;

    assign op_e   = alu_op_e'(op_sel);
    assign opnd_b = state_q.acc[DW-1:0];

    ripple_adder #(.W(DW)) u_rca (
        .x_in    (data_a),
        .y_in    (opnd_b),
        .c_in    (1'b0),
        .sum_out (rc_sum)
    );

    alu_core #(.DW(DW), .RW(RW)) u_alu (
        .op     (op_e),
        .a      (data_a),
        .b      (opnd_b),
        .rc_sum (rc_sum),
        .y      (alu_y)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.acc = '0;
        end else if (op_e != OP_HOLD) begin
            state_d.acc = alu_y;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign result = state_q.acc;

    // Checker state: whether the previous edge saw reset asserted.
    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_clears_R1: assert (result == '0)
                else $error("reset did not clear result");
        end
    end

    // Structural adder must agree with an independent sum of the operands.
    assert_ripple_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rc_sum == ((DW+1)'(data_a) + (DW+1)'(opnd_b)));

    // Feedback: operand B is the low nibble of the previous result.
    assert_feedback_add_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd1) |=> result == (RW'($past(data_a)) + RW'($past(result[DW-1:0]))));

    assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2) |=> result[RW-1:DW] == {(RW-DW){result[DW-1]}});

    assert_flag_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3 || op_sel == 3'd4) |=> result[RW-1:1] == '0);

    assert_product_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd6) |=> result == RW'(RW'($past(data_a)) * RW'($past(result[DW-1:0]))));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |=> $stable(result));

endmodule

// File: tb/accum_alu_tb.sv
module accum_alu_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] data_a;
    logic [2:0] op_sel;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q;

    always #5 clk = ~clk;

    accum_alu u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_a (data_a),
        .op_sel (op_sel),
        .result (result)
    );

    function automatic logic [7:0] model_next(input logic [3:0] a, input logic [2:0] op,
                                              input logic [7:0] cur);
        logic [3:0] b;
        logic [11:0] wide;
        b = cur[3:0];
        case (op)
            3'd0, 3'd1: return 8'(a) + 8'(b);
            3'd2: return b[3] ? {4'hF, b} : {4'h0, b};
            3'd3: return (a != 4'd0 || b != 4'd0) ? 8'd1 : 8'd0;
            3'd4: return (a == 4'hF && b == 4'hF) ? 8'd1 : 8'd0;
            3'd5: begin
                wide = 12'(b);
                for (int k = 0; k < 16; k++) if (k < int'(a)) wide = {wide[10:0], 1'b0};
                return wide[7:0];
            end
            3'd6: return 8'(int'(a) * int'(b));
            default: return cur;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", req, result, exp);
        end
    endtask

    task automatic step(input logic [3:0] a, input logic [2:0] op, input string req);
        @(negedge clk);
        rst_n  = 1'b1;
        data_a = a;
        op_sel = op;
        exp_q  = model_next(a, op, exp_q);
        @(posedge clk);
        #1;
        check(req, exp_q);
    endtask

    task automatic do_reset(input logic [2:0] op, input string req);
        @(negedge clk);
        rst_n  = 1'b0;
        op_sel = op;
        data_a = 4'hA;
        exp_q  = 8'h00;
        @(posedge clk);
        #1;
        check(req, exp_q);
    endtask

    task automatic load(input logic [3:0] v);
        do_reset(3'd7, "R1");
        step(v, 3'd1, "R3");
    endtask

    task automatic t_reset;
        do_reset(3'd0, "R1");
        do_reset(3'd7, "R1");
    endtask

    task automatic t_adders;
        step(4'hF, 3'd0, "R2");               // 15
        step(4'hF, 3'd0, "R2");               // 30: carry in bit 4
        if (result !== 8'h1E) begin errors++; $display("FAIL R2: result=%h expected=1e", result); end
        checks++;
        step(4'h3, 3'd1, "R3");               // 14 + 3
        load(4'hF);
        step(4'hF, 3'd1, "R3");               // 30 with behavioural adder
        step(4'h1, 3'd1, "R3");
    endtask

    task automatic t_signext;
        load(4'h8);
        step(4'h0, 3'd2, "R4");               // F8
        load(4'h7);
        step(4'h5, 3'd2, "R4");               // 07
        load(4'hF);
        step(4'h0, 3'd2, "R4");               // FF
    endtask

    task automatic t_reduce;
        load(4'h0);
        step(4'h0, 3'd3, "R5");               // 0
        load(4'h0);
        step(4'h1, 3'd3, "R5");               // 1
        load(4'h2);
        step(4'h0, 3'd3, "R5");               // 1
        load(4'hF);
        step(4'hF, 3'd4, "R6");               // 1
        load(4'hF);
        step(4'hE, 3'd4, "R6");               // 0
        load(4'h7);
        step(4'hF, 3'd4, "R6");               // 0
    endtask

    task automatic t_shift;
        load(4'h3);
        step(4'h2, 3'd5, "R7");               // 0C
        load(4'hF);
        step(4'h4, 3'd5, "R7");               // F0
        load(4'hF);
        step(4'h7, 3'd5, "R7");               // 80
        load(4'h1);
        step(4'h8, 3'd5, "R7");               // 00
        load(4'h1);
        step(4'h0, 3'd5, "R7");               // 01
    endtask

    task automatic t_mul;
        load(4'hF);
        step(4'hF, 3'd6, "R8");               // E1
        load(4'h7);
        step(4'h3, 3'd6, "R8");               // 15
        load(4'h0);
        step(4'h9, 3'd6, "R8");               // 0
    endtask

    task automatic t_hold;
        load(4'h9);
        step(4'h0, 3'd7, "R9");
        step(4'hF, 3'd7, "R9");
        step(4'h5, 3'd7, "R9");
        load(4'hF);
        step(4'hF, 3'd1, "R3");               // 1E
        step(4'h3, 3'd7, "R9");               // stays 1E
    endtask

    task automatic t_accum;
        do_reset(3'd7, "R1");
        step(4'h5, 3'd1, "R10");              // 05
        step(4'h5, 3'd0, "R10");              // 0A
        step(4'h5, 3'd1, "R10");              // 0F
        step(4'h1, 3'd0, "R10");              // 10
        step(4'h3, 3'd0, "R10");              // B = 0 -> 03, upper bits dropped
        if (result !== 8'h03) begin errors++; $display("FAIL R10: result=%h expected=03", result); end
        checks++;
        step(4'h2, 3'd6, "R10");              // 06
        step(4'h1, 3'd5, "R10");              // 0C
    endtask

    task automatic t_reset_priority;
        load(4'h6);
        do_reset(3'd7, "R1");
        load(4'h6);
        do_reset(3'd1, "R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: result=%h expected=finish", result);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        data_a = 4'h0;
        op_sel = 3'd7;
        exp_q  = 8'h00;
        t_reset();
        t_adders();
        t_signext();
        t_reduce();
        t_shift();
        t_mul();
        t_hold();
        t_accum();
        t_reset_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule